// File: doc/BRIEF.md
# Multi-channel power-good reset supervisor

This block turns per-channel digital threshold flags into one registered, active-low system reset flag. Each supply channel reports three plain levels: whether the channel is switched on, whether its output is above its start threshold (about 85 % of target), and whether it is below its stop threshold (about 80 % of target). A separate input reports that the raw input supply has sagged into its warning band. The analog comparators and any capacitor-timed delay stay outside the block: the delay here is a cycle counter whose terminal count comes in on a port, so the hold-off time scales linearly with that value. For example, 115000 at a 1 MHz tick gives roughly 115 ms.

A channel becomes qualified once it has been enabled for at least one full cycle and shows above-start. It stays qualified across the band between the two thresholds and loses qualification only when it drops below stop or is switched off. The counter runs only while at least one channel is enabled, every enabled channel is qualified and no supply warning is present. Any other condition clears the counter and pulls the flag low on the same clock edge. All pins are plain level signals: there is no data stream and no handshake.

Top module: `pwrgood_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pgood` reads 0 until a full delay has completed. Asserting `rst_n` at any time clears `pgood` and the counter.
- R2: With no bit of `ch_en` set, `pgood` is 0 after the next clock edge, whatever the other inputs are.
- R3: The counter advances only on edges at which every enabled channel is qualified, at least one channel is enabled and `supply_warn` is 0. `pgood` goes to 1 on the (`delay_limit`+1)th consecutive such edge.
- R4: A qualified enabled channel stays qualified while both `ch_above` and `ch_below` are 0 (hysteresis band), so a high `pgood` is kept. A disqualified channel regains qualification only by showing `ch_above`=1.
- R5: If an enabled channel shows `ch_below`=1 at an edge, `pgood` is 0 after that edge. Its later return above start restarts the delay from zero.
- R6: A channel whose `ch_en` bit is 0 has no influence: its `ch_above` and `ch_below` bits are ignored.
- R7: A channel whose `ch_en` bit rises forces `pgood` to 0 at that edge, even if it already shows above-start. A full new delay must complete before `pgood` returns to 1.
- R8: Clearing the last set bit of `ch_en` forces `pgood` to 0 at that edge. Clearing one channel while others stay enabled and qualified leaves `pgood` at 1.
- R9: `supply_warn`=1 forces `pgood` to 0 at that edge and clears the counter. Channel qualification is kept, so after the warning ends a full delay restores `pgood`.
- R10: `delay_limit` sets the delay linearly. A value of 0 raises `pgood` on the first edge at which the conditions of R3 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | NUM_CH | Per-channel enable, bit i is channel i |
| ch_above | input | NUM_CH | Per-channel flag: output above start threshold |
| ch_below | input | NUM_CH | Per-channel flag: output below stop threshold |
| supply_warn | input | 1 | Input supply in warning band |
| delay_limit | input | CNT_W | Terminal count of the hold-off counter |
| pgood | output | 1 | Registered flag: 0 means reset asserted, 1 means all enabled supplies are good |

## Verification
The bench builds the block with three channels and a 24-bit counter. It drives `delay_limit` at 2 for the table walk, so every enable, drop, warning and recovery sequence completes within a few cycles and the hysteresis band and restart-from-zero cases can each be observed. It then uses 10, to confirm the exact edge on which the flag rises, and 0, to reach the shortest-delay boundary. With three channels, the bench can enable a second channel on top of a running one and can disable one of two channels, which the single-channel cases cannot show.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  // Per-channel threshold flags as seen by one qualifier slice
  typedef struct packed {
    logic en;
    logic above;
    logic below;
  } chan_flags_t;
endpackage

// File: rtl/pgs_chan_qual.sv
module pgs_chan_qual
  import pgs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  chan_flags_t flags,
  output logic        qual_nxt
);
  logic en_d;
  logic qual_q;

  // A channel qualifies only after one full enabled cycle, then holds
  // through the hysteresis band until it falls below stop or is disabled.
  always_comb begin
    qual_nxt = flags.en & ~flags.below & (qual_q | (flags.above & en_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= 1'b0;
      qual_q <= 1'b0;
    end else begin
      en_d   <= flags.en;
      qual_q <= qual_nxt;
    end
  end
endmodule

// File: rtl/pgs_delay_timer.sv
module pgs_delay_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (!armed) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else begin
      expired <= (cnt_q >= limit);
      if (cnt_q < limit) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrgood_supervisor.sv
module pwrgood_supervisor
  import pgs_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_above,
  input  logic [NUM_CH-1:0] ch_below,
  input  logic              supply_warn,
  input  logic [CNT_W-1:0]  delay_limit,
  output logic              pgood
);
  logic [NUM_CH-1:0] qual_nxt;
  logic              any_en;
  logic              all_qual;
  logic              armed;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    chan_flags_t flags;
    assign flags = '{en: ch_en[i], above: ch_above[i], below: ch_below[i]};
    pgs_chan_qual u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (flags),
      .qual_nxt (qual_nxt[i])
    );
  end

  always_comb begin
    any_en   = |ch_en;
    all_qual = &(qual_nxt | ~ch_en);
    armed    = any_en & all_qual & ~supply_warn;
  end

  pgs_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (armed),
    .limit   (delay_limit),
    .expired (pgood)
  );
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_above,
  input logic [NUM_CH-1:0] ch_below,
  input logic              supply_warn,
  input logic [CNT_W-1:0]  delay_limit,
  input logic              pgood
);
  logic [NUM_CH-1:0] en_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_seen <= '0;
    else        en_seen <= ch_en;
  end

  // R2
  p_none_enabled_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ch_en) |=> !pgood);

  // R5
  p_below_stop_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_en & ch_below)) |=> !pgood);

  // R7
  p_new_enable_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_en & ~en_seen)) |=> !pgood);

  // R9
  p_warn_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    supply_warn |=> !pgood);

  // R4: a good flag is held while nothing disqualifying happens
  p_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && !supply_warn && (|ch_en) && !(|(ch_en & ch_below)) &&
     !(|(ch_en & ~en_seen)) && $stable(delay_limit)) |=> pgood);
endmodule

bind pwrgood_supervisor pgs_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_en       (ch_en),
  .ch_above    (ch_above),
  .ch_below    (ch_below),
  .supply_warn (supply_warn),
  .delay_limit (delay_limit),
  .pgood       (pgood)
);

// File: tb/test_pwrgood_supervisor.sv
module test_pwrgood_supervisor;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 24;
  localparam int NVEC   = 23;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] ch_above;
  logic [NUM_CH-1:0] ch_below;
  logic              supply_warn;
  logic [CNT_W-1:0]  delay_limit;
  logic              pgood;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwrgood_supervisor #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_pwrgood_supervisor (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_above(ch_above),
    .ch_below(ch_below), .supply_warn(supply_warn),
    .delay_limit(delay_limit), .pgood(pgood)
  );

  // Fields: req[14:11] en[10:8] above[7:5] below[4:2] warn[1] expected[0]
  // Walked with delay_limit = 2: flag rises on the 3rd consecutive good edge.
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd7, 3'b001, 3'b001, 3'b000, 1'b0, 1'b0}, //  0 R7 first enable
    {4'd3, 3'b001, 3'b001, 3'b000, 1'b0, 1'b0}, //  1 R3 count 1
    {4'd3, 3'b001, 3'b001, 3'b000, 1'b0, 1'b0}, //  2 R3 count 2
    {4'd3, 3'b001, 3'b001, 3'b000, 1'b0, 1'b1}, //  3 R3 released
    {4'd3, 3'b001, 3'b001, 3'b000, 1'b0, 1'b1}, //  4 R3 held
    {4'd4, 3'b001, 3'b000, 3'b000, 1'b0, 1'b1}, //  5 R4 in band, held
    {4'd5, 3'b001, 3'b000, 3'b001, 1'b0, 1'b0}, //  6 R5 below stop
    {4'd4, 3'b001, 3'b000, 3'b000, 1'b0, 1'b0}, //  7 R4 band does not requalify
    {4'd5, 3'b001, 3'b001, 3'b000, 1'b0, 1'b0}, //  8 R5 restart count 1
    {4'd5, 3'b001, 3'b001, 3'b000, 1'b0, 1'b0}, //  9 R5 count 2
    {4'd5, 3'b001, 3'b001, 3'b000, 1'b0, 1'b1}, // 10 R5 released again
    {4'd7, 3'b011, 3'b011, 3'b000, 1'b0, 1'b0}, // 11 R7 add channel already above
    {4'd7, 3'b011, 3'b011, 3'b000, 1'b0, 1'b0}, // 12 R7 count 1
    {4'd7, 3'b011, 3'b011, 3'b000, 1'b0, 1'b0}, // 13 R7 count 2
    {4'd7, 3'b011, 3'b011, 3'b000, 1'b0, 1'b1}, // 14 R7 released
    {4'd6, 3'b011, 3'b011, 3'b100, 1'b0, 1'b1}, // 15 R6 disabled channel below
    {4'd9, 3'b011, 3'b011, 3'b000, 1'b1, 1'b0}, // 16 R9 warning
    {4'd9, 3'b011, 3'b011, 3'b000, 1'b0, 1'b0}, // 17 R9 count 1
    {4'd9, 3'b011, 3'b011, 3'b000, 1'b0, 1'b0}, // 18 R9 count 2
    {4'd9, 3'b011, 3'b011, 3'b000, 1'b0, 1'b1}, // 19 R9 released
    {4'd8, 3'b001, 3'b001, 3'b000, 1'b0, 1'b1}, // 20 R8 drop one of two
    {4'd8, 3'b000, 3'b001, 3'b000, 1'b0, 1'b0}, // 21 R8 last disabled
    {4'd2, 3'b000, 3'b111, 3'b000, 1'b0, 1'b0}  // 22 R2 none enabled
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (pgood !== exp) begin
      errors++;
      $display("FAIL %s: pgood=%b expected %b", tag, pgood, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ch_en = '0; ch_above = '0; ch_below = '0;
    supply_warn = 1'b0; delay_limit = CNT_W'(2);
    step(3);
    check(1'b0, "R1 during reset");
    rst_n = 1'b1;
    step(1);
    check(1'b0, "R1 after reset");

    for (int i = 0; i < NVEC; i++) begin
      ch_en       = VEC[i][10:8];
      ch_above    = VEC[i][7:5];
      ch_below    = VEC[i][4:2];
      supply_warn = VEC[i][1];
      step(1);
      check(VEC[i][0], $sformatf("vector %0d R%0d", i, VEC[i][14:11]));
    end

    // R10: limit 0 releases on the first qualified edge after enable
    delay_limit = '0;
    ch_en = 3'b010; ch_above = 3'b010; ch_below = '0;
    step(1);
    check(1'b0, "R10 limit0 enable edge");
    step(1);
    check(1'b1, "R10 limit0 first good edge");

    // R10/R3: limit 10 releases on the 11th good edge
    ch_en = '0;
    step(1);
    check(1'b0, "R2 cleared before limit10");
    delay_limit = CNT_W'(10);
    ch_en = 3'b100; ch_above = 3'b100;
    step(1);
    check(1'b0, "R7 limit10 enable edge");
    step(10);
    check(1'b0, "R10 limit10 still low at 10");
    step(1);
    check(1'b1, "R10 limit10 released at 11");

    // R1: reset mid-run clears the flag
    rst_n = 1'b0;
    step(1);
    check(1'b0, "R1 mid-run reset");
    rst_n = 1'b1;
    step(1);
    check(1'b0, "R1 first edge after reset (enable seen new)");

    finish_run();
  end
endmodule